// File: doc/BRIEF.md
# Line-Cycle Synchronized Energy Latch

This block holds one signed energy register per phase. Each register counts signed energy pulses. In continuous mode, every pulse updates the visible register of its phase at once. A software read can optionally clear that register. In line-cycle mode, the pulses go to hidden per-phase integrators instead. The integration window is tied to zero-crossing strobes from a voltage channel, and its length is a programmed number of half line cycles. At the end of each window, all phases copy their integrator totals into the visible registers at the same instant. The integrators then restart, and a one-cycle completion flag is raised.

Software uses line-cycle mode to read energy taken over a whole number of half cycles. This removes the ripple that a window starting partway through a cycle would add. The zero-crossing detector is outside this block, and only its strobe comes in. Every input is sampled on the rising clock edge. Every output is registered.

Top module: `lcyc_energy_latch`

## Requirements
- R1: During a synchronous reset, every visible register reads 0 and `xfer_done` is low.
- R2: With `lc_mode_en` low, a cycle with `pulse_vld[i]` set changes phase i's visible register by +1 (`pulse_neg[i]`=0) or by -1 (`pulse_neg[i]`=1) at the next edge. Phase i's slot is bits [32*i+31:32*i] of `energy_out`.
- R3: With `lc_mode_en` low and `clr_on_rd_en` high, `rd_clr[i]` makes phase i's register equal to that cycle's pulse step (0 when there is no pulse). With `clr_on_rd_en` low, `rd_clr` has no effect.
- R4: With `lc_mode_en` high, the visible registers change only at a transfer.
- R5: After line-cycle mode is enabled, the first zero crossing opens a window. With N = `half_cyc_cnt`, the transfer happens on the N-th zero crossing after the opening one. The transferred value is the sum of the pulse steps from the opening cycle up to the cycle before the transfer.
- R6: A pulse in the cycle of a transfer is not part of the snapshot being transferred. It counts into the next window.
- R7: All three phases take their snapshots at the same clock edge.
- R8: `xfer_done` is high for exactly the cycle in which a new snapshot first appears. When zero crossings come on consecutive cycles with N=1, it stays high across consecutive cycles.
- R9: While line-cycle mode is active, `rd_clr` has no effect even when `clr_on_rd_en` is high.
- R10: Enabling line-cycle mode discards integrator content. Pulses before the first zero crossing are not counted.
- R11: A programmed count of 0 behaves as a count of 1.
- R12: When line-cycle mode is switched off, the visible registers keep the last snapshot and resume counting pulses from that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lc_mode_en | input | 1 | Selects line-cycle mode |
| clr_on_rd_en | input | 1 | Allows clear-on-read in continuous mode |
| half_cyc_cnt | input | 16 | Window length in half line cycles |
| zc_strobe | input | 1 | One-cycle zero-crossing strobe |
| pulse_vld | input | 3 | Per-phase energy pulse strobe |
| pulse_neg | input | 3 | Per-phase pulse sign, 1 = negative |
| rd_clr | input | 3 | Per-phase read strobe that may clear |
| energy_out | output | 96 | Visible registers, phase i at [32*i+31:32*i] |
| xfer_done | output | 1 | One-cycle snapshot completion flag |

## Verification
The assertions check the following on every cycle:
- the reset values;
- that the visible registers stay frozen between transfers in line-cycle mode, whatever pulses or reads arrive;
- that an idle phase holds in continuous mode;
- that a clearing read with no pulse leaves zero;
- that the completion flag only follows a zero crossing taken in line-cycle mode.

Only the bench scenarios can show:
- the window arithmetic: which crossing ends a window, what the snapshot sums to, and where a pulse in the transfer cycle is counted;
- that a count of 0 acts as 1;
- that pulses before the first crossing are dropped;
- the value that continuous counting resumes from after leaving line-cycle mode.

// File: rtl/lcyc_pkg.sv
package lcyc_pkg;

    typedef enum logic [1:0] {
        ACC_ZERO = 2'd0,
        ACC_LOAD = 2'd1,
        ACC_ADD  = 2'd2
    } acc_op_e;

    typedef enum logic {
        WIN_ARMED = 1'b0,
        WIN_RUN   = 1'b1
    } win_state_e;

    typedef struct packed {
        logic    xfer;
        acc_op_e op;
    } win_ctl_t;

    // Two-bit signed step of one pulse strobe: 0, +1 or -1.
    function automatic logic signed [1:0] pulse_step(input logic vld, input logic neg);
        if (!vld)
            return 2'sd0;
        else if (neg)
            return -2'sd1;
        else
            return 2'sd1;
    endfunction

endpackage

// File: rtl/lcyc_window_ctrl.sv
module lcyc_window_ctrl
    import lcyc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lc_en,
    input  logic             zc,
    input  logic [CNT_W-1:0] half_cnt,
    output win_ctl_t         ctl
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    win_state_e       state_q;
    logic [CNT_W-1:0] left_q;
    logic [CNT_W-1:0] n_eff;
    logic             last_zc;

    assign n_eff   = (half_cnt == '0) ? ONE : half_cnt;
    assign last_zc = (left_q <= ONE);

    always_comb begin
        ctl.xfer = 1'b0;
        ctl.op   = ACC_ZERO;
        if (lc_en) begin
            if (state_q == WIN_ARMED) begin
                ctl.op = zc ? ACC_LOAD : ACC_ZERO;
            end else if (zc && last_zc) begin
                ctl.xfer = 1'b1;
                ctl.op   = ACC_LOAD;
            end else begin
                ctl.op = ACC_ADD;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !lc_en) begin
            state_q <= WIN_ARMED;
            left_q  <= '0;
        end else if (zc) begin
            if (state_q == WIN_ARMED) begin
                state_q <= WIN_RUN;
                left_q  <= n_eff;
            end else begin
                left_q  <= last_zc ? n_eff : left_q - ONE;
            end
        end
    end

endmodule

// File: rtl/lcyc_phase_chan.sv
module lcyc_phase_chan
    import lcyc_pkg::*;
#(
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lc_en,
    input  logic             clr_on_rd,
    input  logic             rd_clr,
    input  logic             vld,
    input  logic             neg,
    input  win_ctl_t         ctl,
    output logic [ACC_W-1:0] vis
);

    logic signed [1:0]       step2;
    logic signed [ACC_W-1:0] delta;
    logic signed [ACC_W-1:0] acc_q;
    logic signed [ACC_W-1:0] vis_q;

    assign step2 = pulse_step(vld, neg);
    assign delta = {{(ACC_W-2){step2[1]}}, step2};

    // Hidden integrator used only in line-cycle mode.
    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else begin
            unique case (ctl.op)
                ACC_LOAD: acc_q <= delta;
                ACC_ADD:  acc_q <= acc_q + delta;
                default:  acc_q <= '0;
            endcase
        end
    end

    // Visible register: snapshot in line-cycle mode, running count otherwise.
    always_ff @(posedge clk) begin
        if (rst) begin
            vis_q <= '0;
        end else if (lc_en) begin
            if (ctl.xfer)
                vis_q <= acc_q;
        end else if (clr_on_rd && rd_clr) begin
            vis_q <= delta;
        end else begin
            vis_q <= vis_q + delta;
        end
    end

    assign vis = vis_q;

endmodule

// File: rtl/lcyc_energy_latch.sv
module lcyc_energy_latch
    import lcyc_pkg::*;
#(
    parameter int NPH   = 3,
    parameter int ACC_W = 32,
    parameter int CNT_W = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 lc_mode_en,
    input  logic                 clr_on_rd_en,
    input  logic [CNT_W-1:0]     half_cyc_cnt,
    input  logic                 zc_strobe,
    input  logic [NPH-1:0]       pulse_vld,
    input  logic [NPH-1:0]       pulse_neg,
    input  logic [NPH-1:0]       rd_clr,
    output logic [NPH*ACC_W-1:0] energy_out,
    output logic                 xfer_done
);

    win_ctl_t ctl;
    logic     done_q;

    lcyc_window_ctrl #(.CNT_W(CNT_W)) u_win (
        .clk      (clk),
        .rst      (rst),
        .lc_en    (lc_mode_en),
        .zc       (zc_strobe),
        .half_cnt (half_cyc_cnt),
        .ctl      (ctl)
    );

    for (genvar p = 0; p < NPH; p++) begin : g_ph
        lcyc_phase_chan #(.ACC_W(ACC_W)) u_chan (
            .clk       (clk),
            .rst       (rst),
            .lc_en     (lc_mode_en),
            .clr_on_rd (clr_on_rd_en),
            .rd_clr    (rd_clr[p]),
            .vld       (pulse_vld[p]),
            .neg       (pulse_neg[p]),
            .ctl       (ctl),
            .vis       (energy_out[p*ACC_W +: ACC_W])
        );
    end

    always_ff @(posedge clk) begin
        if (rst)
            done_q <= 1'b0;
        else
            done_q <= ctl.xfer;
    end

    assign xfer_done = done_q;

endmodule

// File: rtl/lcyc_latch_checker.sv
module lcyc_latch_checker #(
    parameter int NPH   = 3,
    parameter int ACC_W = 32
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 lc_mode_en,
    input logic                 clr_on_rd_en,
    input logic                 zc_strobe,
    input logic [NPH-1:0]       pulse_vld,
    input logic [NPH-1:0]       rd_clr,
    input logic [NPH*ACC_W-1:0] energy_out,
    input logic                 xfer_done
);

    // R1: reset values
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (energy_out == '0 && !xfer_done));

    // R8: the flag only follows a zero crossing taken in line-cycle mode
    assert_done_after_zc_R8: assert property (@(posedge clk) disable iff (rst)
        xfer_done |-> ($past(zc_strobe) && $past(lc_mode_en)));

    // R4 / R9: registers are frozen between transfers in line-cycle mode
    assert_snapshot_hold_R4: assert property (@(posedge clk) disable iff (rst)
        ($past(lc_mode_en) && !$past(rst) && !xfer_done) |-> $stable(energy_out));

    for (genvar g = 0; g < NPH; g++) begin : g_chk
        // R2: an idle phase holds in continuous mode
        assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
            (!lc_mode_en && !pulse_vld[g] && !(clr_on_rd_en && rd_clr[g]))
            |=> $stable(energy_out[g*ACC_W +: ACC_W]));

        // R3: a clearing read with no pulse leaves zero
        assert_read_clear_R3: assert property (@(posedge clk) disable iff (rst)
            (!lc_mode_en && clr_on_rd_en && rd_clr[g] && !pulse_vld[g])
            |=> (energy_out[g*ACC_W +: ACC_W] == '0));
    end

endmodule

bind lcyc_energy_latch lcyc_latch_checker #(.NPH(NPH), .ACC_W(ACC_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .lc_mode_en   (lc_mode_en),
    .clr_on_rd_en (clr_on_rd_en),
    .zc_strobe    (zc_strobe),
    .pulse_vld    (pulse_vld),
    .rd_clr       (rd_clr),
    .energy_out   (energy_out),
    .xfer_done    (xfer_done)
);

// File: tb/tb_lcyc_energy_latch.sv
module tb_lcyc_energy_latch;

    logic        clk = 1'b0;
    logic        rst;
    logic        lc_mode_en;
    logic        clr_on_rd_en;
    logic [15:0] half_cyc_cnt;
    logic        zc_strobe;
    logic [2:0]  pulse_vld;
    logic [2:0]  pulse_neg;
    logic [2:0]  rd_clr;
    logic [95:0] energy_out;
    logic        xfer_done;

    int n_chk  = 0;
    int n_fail = 0;
    bit ended  = 0;

    always #4 clk = ~clk;

    lcyc_energy_latch dut (
        .clk          (clk),
        .rst          (rst),
        .lc_mode_en   (lc_mode_en),
        .clr_on_rd_en (clr_on_rd_en),
        .half_cyc_cnt (half_cyc_cnt),
        .zc_strobe    (zc_strobe),
        .pulse_vld    (pulse_vld),
        .pulse_neg    (pulse_neg),
        .rd_clr       (rd_clr),
        .energy_out   (energy_out),
        .xfer_done    (xfer_done)
    );

    function automatic logic [31:0] ph(input int i);
        return energy_out[i*32 +: 32];
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, $signed(act), $signed(exp));
        end
    endtask

    task automatic chk_all(input string tag, input int e0, input int e1, input int e2);
        chk({tag, " ph0"}, ph(0), 32'(e0));
        chk({tag, " ph1"}, ph(1), 32'(e1));
        chk({tag, " ph2"}, ph(2), 32'(e2));
    endtask

    // Drive one cycle of stimulus at the falling edge, sample after the next rising edge.
    task automatic tick(input logic [2:0] v, input logic [2:0] n, input logic z, input logic [2:0] r);
        pulse_vld = v;
        pulse_neg = n;
        zc_strobe = z;
        rd_clr    = r;
        @(posedge clk);
        @(negedge clk);
        pulse_vld = '0;
        pulse_neg = '0;
        zc_strobe = 1'b0;
        rd_clr    = '0;
    endtask

    task automatic t_reset;
        rst = 1'b1; lc_mode_en = 0; clr_on_rd_en = 0; half_cyc_cnt = 16'd1;
        zc_strobe = 0; pulse_vld = '0; pulse_neg = '0; rd_clr = '0;
        repeat (4) @(negedge clk);
        chk_all("R1 reset", 0, 0, 0);
        chk("R1 reset done", 32'(xfer_done), 32'd0);
        rst = 1'b0;
    endtask

    task automatic t_continuous;
        for (int k = 0; k < 3; k++) tick(3'b011, 3'b010, 0, 3'b000);
        for (int k = 0; k < 2; k++) tick(3'b001, 3'b000, 0, 3'b000);
        for (int k = 0; k < 2; k++) tick(3'b001, 3'b001, 0, 3'b000);
        tick(3'b100, 3'b100, 0, 3'b000);
        chk_all("R2 continuous count", 3, -3, -1);
    endtask

    task automatic t_read_clear;
        clr_on_rd_en = 0;
        tick(3'b000, 3'b000, 0, 3'b001);
        chk("R3 read without clear enable", ph(0), 32'd3);
        clr_on_rd_en = 1;
        tick(3'b001, 3'b000, 0, 3'b001);
        chk("R3 clear with pulse", ph(0), 32'd1);
        tick(3'b000, 3'b000, 0, 3'b010);
        chk_all("R3 clear no pulse", 1, 0, -1);
    endtask

    task automatic t_first_window;
        half_cyc_cnt = 16'd3;
        lc_mode_en   = 1;
        tick(3'b111, 3'b000, 0, 3'b000);
        chk_all("R4 hold before first crossing", 1, 0, -1);
        tick(3'b000, 3'b000, 0, 3'b111);
        chk_all("R9 read ignored in line-cycle mode", 1, 0, -1);
        tick(3'b001, 3'b000, 1, 3'b000);              // opening crossing
        tick(3'b011, 3'b010, 0, 3'b000);
        tick(3'b101, 3'b010, 0, 3'b000);
        tick(3'b000, 3'b000, 1, 3'b000);
        for (int k = 0; k < 3; k++) tick(3'b010, 3'b010, 0, 3'b000);
        tick(3'b000, 3'b000, 1, 3'b000);
        chk_all("R5 no transfer before N-th crossing", 1, 0, -1);
        chk("R8 flag low mid-window", 32'(xfer_done), 32'd0);
        tick(3'b001, 3'b000, 1, 3'b000);              // transfer crossing
        chk_all("R5 R7 R10 first snapshot", 3, -4, 1);
        chk("R8 flag with snapshot", 32'(xfer_done), 32'd1);
        tick(3'b000, 3'b000, 0, 3'b000);
        chk("R8 flag lasts one cycle", 32'(xfer_done), 32'd0);
    endtask

    task automatic t_second_window;
        tick(3'b001, 3'b000, 0, 3'b000);
        tick(3'b001, 3'b000, 0, 3'b000);
        tick(3'b000, 3'b000, 1, 3'b000);
        tick(3'b000, 3'b000, 1, 3'b000);
        chk_all("R4 hold inside second window", 3, -4, 1);
        tick(3'b000, 3'b000, 1, 3'b000);
        chk_all("R6 transfer-cycle pulse in next window", 3, 0, 0);
        chk("R8 second flag", 32'(xfer_done), 32'd1);
    endtask

    task automatic t_zero_count;
        lc_mode_en = 0;
        tick(3'b000, 3'b000, 0, 3'b000);
        half_cyc_cnt = 16'd0;
        lc_mode_en   = 1;
        tick(3'b000, 3'b000, 1, 3'b000);              // opening crossing
        tick(3'b001, 3'b000, 0, 3'b000);
        tick(3'b001, 3'b000, 0, 3'b000);
        tick(3'b000, 3'b000, 1, 3'b000);
        chk_all("R11 count 0 acts as 1", 2, 0, 0);
        chk("R11 flag", 32'(xfer_done), 32'd1);
        tick(3'b000, 3'b000, 1, 3'b000);
        chk_all("R11 back-to-back crossing", 0, 0, 0);
        chk("R8 flag on consecutive transfers", 32'(xfer_done), 32'd1);
    endtask

    task automatic t_leave_mode;
        tick(3'b100, 3'b000, 0, 3'b000);
        lc_mode_en = 0;
        tick(3'b110, 3'b100, 0, 3'b000);
        chk_all("R12 resume continuous", 0, 1, -1);
        chk("R12 no flag", 32'(xfer_done), 32'd0);
    endtask

    initial begin
        #(8 * 20000);
        if (!ended) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_continuous();
        t_read_clear();
        t_first_window();
        t_second_window();
        t_zero_count();
        t_leave_mode();
        ended = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule